// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM that answers a three-wire, clocked command protocol. One system clock runs it. The chip-select, serial-clock and data-in pins are brought into that clock domain through two-flop synchronizers. Edges are then found by comparing each synchronized level with its value one clock earlier. Each command is shifted in bit by bit on rising serial-clock edges and decoded into a read, a single-word write or erase, a whole-array write or erase, or a change to a write-enable latch. The words live in an on-chip register array.

Programming operations are guarded by the write-enable latch. They are launched by the falling edge of chip select. They then run for a fixed number of system clocks, and any command that arrives during that time is dropped. A host that raises chip select during the cycle can poll the data-out pin for busy (0) or ready (1). The host dismisses that status with a rising serial-clock edge while data-in is high.

Top module: `mw_eeprom`

## Requirements
- R1: A command opens with a 1 on data-in at a rising serial-clock edge while chip select is high. The next two bits are the opcode: 10 read, 01 write, 11 erase, 00 extended. After the opcode come ADDR_W address bits, MSB first. For the extended opcode, the two top address bits choose the command: 11 enable, 00 disable, 01 write-all, 10 erase-all.
- R2: After reset every word reads all ones and the write-enable latch is clear, so write, erase, write-all and erase-all change nothing.
- R3: An enable command sets the latch. A disable command clears it, and any programming command that follows has no effect.
- R4: A write command carries DATA_W data bits, MSB first, after the address. When the latch is set, the falling edge of chip select after the last data bit stores that word at the addressed location and leaves every other location unchanged.
- R5: A write-all command carries DATA_W data bits. Under the latch, the next chip-select fall stores that word in every location.
- R6: An erase command sets the addressed word to all ones. An erase-all command sets every word to all ones. Both take effect on the chip-select fall and only under the latch.
- R7: In a read, data-out shows a 0 after the last address bit. Each following rising serial-clock edge then presents the next bit of the addressed word, MSB first.
- R8: A programming cycle stays busy for TWP_CLKS system clocks from the chip-select fall. While chip select has been high for TCS_CLKS clocks during or after that cycle, data-out reads 0 while busy and 1 once ready.
- R9: If chip select is first raised only after the cycle has ended, no status is shown and data-out stays 0.
- R10: A rising serial-clock edge with chip select and data-in both high clears a pending status, and data-out returns to 0.
- R11: Every command bit that arrives during a programming cycle is ignored, so it can neither start nor change a programming operation.
- R12: Data-out is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read data or busy/ready status |

## Verification
The hardest situation to reach is a full command arriving in the middle of a programming cycle while the status flag is pending. To get there, the stimulus drops chip select to launch a write and raises it again within a few clocks. It then clocks a complete second write frame into the busy window and drops chip select once more. After the cycle ends, a read-back shows that only the first word landed. Separate sequences raise chip select before and after the end of the cycle, so both the shown status and the suppressed status can be observed.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_ERASE, OP_WEN, OP_WDS, OP_WRALL, OP_ERAL
  } mw_op_e;

  // opcode bits plus the two top address bits select the command
  function automatic mw_op_e mw_decode(input logic [1:0] opc, input logic [1:0] ext);
    mw_op_e r;
    case (opc)
      2'b10: r = OP_READ;
      2'b01: r = OP_WRITE;
      2'b11: r = OP_ERASE;
      default: begin
        case (ext)
          2'b11:   r = OP_WEN;
          2'b00:   r = OP_WDS;
          2'b01:   r = OP_WRALL;
          default: r = OP_ERAL;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic logic mw_is_bulk(input mw_op_e op);
    return (op == OP_WRALL) || (op == OP_ERAL);
  endfunction

  function automatic logic mw_is_erase(input mw_op_e op);
    return (op == OP_ERASE) || (op == OP_ERAL);
  endfunction

  // header length: two opcode bits plus the address
  function automatic int mw_hdr_len(input int addr_w);
    return 2 + addr_w;
  endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[0], pin_i[g]};
    end
    assign lvl_o[g] = stg[1];
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int TWP_CLKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(TWP_CLKS + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start_i)        left_q <= CW'(TWP_CLKS);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);

  p_idle_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  p_busy_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_one_i,
  input  logic              wr_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_all_i || (wr_one_i && (wr_addr_i == ADDR_W'(w)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= '1;
      else if (hit) word_q[w] <= wdata_i;
    end
  end

  assign rdata_o = word_q[rd_addr_i];

  p_single_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_one_i && wr_all_i));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int TWP_CLKS = 400,
  parameter int TCS_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int HDR_W = mw_hdr_len(ADDR_W);
  localparam int CNT_W = $clog2(HDR_W + DATA_W + 1);
  localparam int TCS_W = $clog2(TCS_CLKS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_HOLD} st_e;

  logic [2:0] lvl;
  logic cs_s, sk_s, di_s, cs_d, sk_d;
  logic cs_rise, cs_fall, sk_rise;

  mw_pin_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({cs_i, sk_i, di_i}), .lvl_o(lvl)
  );
  assign {cs_s, sk_s, di_s} = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cs_d <= 1'b0; sk_d <= 1'b0; end
    else        begin cs_d <= cs_s; sk_d <= sk_s; end
  end
  assign cs_rise = cs_s & ~cs_d;
  assign cs_fall = ~cs_s & cs_d;
  assign sk_rise = sk_s & ~sk_d;

  st_e                st;
  logic [CNT_W-1:0]   cnt;
  logic [HDR_W-2:0]   hdr_q;
  logic [HDR_W-1:0]   hdr_nxt;
  logic [DATA_W-1:0]  dat_q, rd_sh, rd_word;
  mw_op_e             op_q, op_nxt;
  logic               wen_q, rd_bit, do_q;
  logic               busy, rb_pend, rb_show, clr_evt, sk_take, prog_start;
  logic [TCS_W-1:0]   tcs_cnt;

  // named internal events
  assign clr_evt    = cs_s & di_s & sk_rise & rb_pend;
  assign sk_take    = cs_s & sk_rise & ~busy & ~clr_evt;
  assign hdr_nxt    = {hdr_q, di_s};
  assign op_nxt     = mw_decode(hdr_nxt[HDR_W-1 -: 2], hdr_nxt[ADDR_W-1 -: 2]);
  assign prog_start = cs_fall & (st == ST_ARMED) & wen_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; hdr_q <= '0; dat_q <= '0; rd_sh <= '0;
      op_q <= OP_NONE; wen_q <= 1'b0; rd_bit <= 1'b0;
    end else if (!cs_s) begin
      st <= ST_IDLE; cnt <= '0; rd_bit <= 1'b0;
    end else if (sk_take) begin
      case (st)
        ST_IDLE: if (di_s) begin st <= ST_HDR; cnt <= '0; end
        ST_HDR: begin
          hdr_q <= hdr_nxt[HDR_W-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(HDR_W - 1)) begin
            op_q <= op_nxt;
            cnt  <= '0;
            case (op_nxt)
              OP_READ:            begin st <= ST_READ; rd_sh <= rd_word; rd_bit <= 1'b0; end
              OP_WRITE, OP_WRALL: st <= ST_DATA;
              OP_ERASE, OP_ERAL:  st <= ST_ARMED;
              OP_WEN:             begin wen_q <= 1'b1; st <= ST_HOLD; end
              OP_WDS:             begin wen_q <= 1'b0; st <= ST_HOLD; end
              default:            st <= ST_HOLD;
            endcase
          end
        end
        ST_DATA: begin
          dat_q <= {dat_q[DATA_W-2:0], di_s};
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) st <= ST_ARMED;
        end
        ST_READ: begin
          rd_bit <= rd_sh[DATA_W-1];
          rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
          cnt    <= cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) st <= ST_HOLD;
        end
        ST_HOLD:  rd_bit <= 1'b0;
        default:  st <= st;
      endcase
    end
  end

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_one_i(prog_start & ~mw_is_bulk(op_q)),
    .wr_all_i(prog_start & mw_is_bulk(op_q)),
    .wr_addr_i(hdr_q[ADDR_W-1:0]),
    .wdata_i(mw_is_erase(op_q) ? {DATA_W{1'b1}} : dat_q),
    .rd_addr_i(hdr_nxt[ADDR_W-1:0]),
    .rdata_o(rd_word)
  );

  mw_prog_timer #(.TWP_CLKS(TWP_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(prog_start), .busy_o(busy)
  );

  // ready/busy status flag and chip-select settle counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rb_pend <= 1'b0;
    else if (prog_start)         rb_pend <= 1'b1;
    else if (clr_evt)            rb_pend <= 1'b0;
    else if (cs_rise && !busy)   rb_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tcs_cnt <= '0;
    else if (!cs_s)                      tcs_cnt <= '0;
    else if (tcs_cnt != TCS_W'(TCS_CLKS)) tcs_cnt <= tcs_cnt + 1'b1;
  end
  assign rb_show = rb_pend & cs_s & (tcs_cnt == TCS_W'(TCS_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       do_q <= 1'b0;
    else if (!cs_s)   do_q <= 1'b0;
    else if (rb_show) do_q <= ~busy;
    else              do_q <= rd_bit;
  end
  assign do_o = do_q;

  p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen_q);
  p_quiet_cs_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_s) |-> !do_o);
  p_ready_shown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_show && !busy) |=> do_o);
  p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !rb_pend);
endmodule

// File: tb/mw_eeprom_bench.sv
`timescale 1ns/1ps
module mw_eeprom_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int TWP = 400;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  wire  dout;
  int   n_checks = 0, n_fail = 0;
  logic [DW-1:0] got;
  logic [DW-1:0] exp_q[$];
  string         req_q[$];
  event          rd_ev;

  always #2 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .TWP_CLKS(TWP), .TCS_CLKS(3)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(dout)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; idle(HP); sk = 1'b1; idle(HP); sk = 1'b0;
  endtask

  // R1 frame: start bit, opcode, address MSB first
  task automatic hdr(input logic [1:0] opc, input logic [AW-1:0] a);
    cs = 1'b1; idle(4);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(opc[i]);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic data(input logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic drop_cs();
    di = 1'b0; idle(4); cs = 1'b0; idle(4);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    hdr(2'b01, a); data(d); drop_cs(); idle(TWP + 40);
  endtask

  task automatic ext(input logic [1:0] sel);
    hdr(2'b00, {sel, {(AW-2){1'b0}}});
  endtask

  // scoreboard driver: push expected word, then shift the read out
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    exp_q.push_back(exp); req_q.push_back(req);
    hdr(2'b10, a);
    idle(HP);
    chk(dout == 1'b0, "R7 dummy bit", {15'b0, dout}, '0);
    for (int i = DW - 1; i >= 0; i--) begin
      sk = 1'b1; idle(HP); got[i] = dout; sk = 1'b0; idle(HP);
    end
    drop_cs();
    -> rd_ev;
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_ev);
    chk(got == exp_q[0], req_q[0], got, exp_q[0]);
    void'(exp_q.pop_front());
    void'(req_q.pop_front());
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle(5); rst_n = 1'b1; idle(5);
    chk(dout == 1'b0, "R12 reset output", {15'b0, dout}, '0);
    rd(6'd5, 16'hFFFF, "R2 reset contents");
    wr(6'd5, 16'h1234);
    rd(6'd5, 16'hFFFF, "R2 write without latch");

    ext(2'b11); drop_cs();                 // enable
    wr(6'd5, 16'hA5C3);
    rd(6'd5, 16'hA5C3, "R4 write stored");
    rd(6'd6, 16'hFFFF, "R4 neighbour unchanged");
    wr(6'd63, 16'h8001);
    rd(6'd63, 16'h8001, "R1 top address");
    rd(6'd0, 16'hFFFF, "R1 bottom address");

    ext(2'b00); drop_cs();                 // disable
    wr(6'd5, 16'h0000);
    rd(6'd5, 16'hA5C3, "R3 blocked after disable");

    ext(2'b11); drop_cs();
    hdr(2'b11, 6'd5); drop_cs(); idle(TWP + 40);
    rd(6'd5, 16'hFFFF, "R6 erase word");

    ext(2'b01); data(16'h3C96); drop_cs(); idle(TWP + 40);
    for (int a = 0; a < 64; a += 9) rd(AW'(a), 16'h3C96, "R5 write-all");
    rd(6'd63, 16'h3C96, "R5 write-all last");

    wr(6'd10, 16'h0F0F);
    ext(2'b10); drop_cs(); idle(TWP + 40);
    for (int a = 1; a < 64; a += 9) rd(AW'(a), 16'hFFFF, "R6 erase-all");

    // R8 / R10 / R12 status timing
    hdr(2'b01, 6'd20); data(16'h5555); drop_cs();
    idle(20);
    chk(dout == 1'b0, "R12 low while busy", {15'b0, dout}, '0);
    cs = 1'b1; idle(20);
    chk(dout == 1'b0, "R8 busy shown", {15'b0, dout}, '0);
    idle(TWP - 80);
    chk(dout == 1'b0, "R8 still busy near end", {15'b0, dout}, '0);
    idle(60);
    chk(dout == 1'b1, "R8 ready shown", {15'b0, dout}, 16'h1);
    send_bit(1'b1); idle(HP);
    chk(dout == 1'b0, "R10 status cleared", {15'b0, dout}, '0);
    drop_cs();
    rd(6'd20, 16'h5555, "R8 word after cycle");

    // R11: second frame during busy is dropped
    hdr(2'b01, 6'd21); data(16'h1111); drop_cs();
    hdr(2'b01, 6'd21); data(16'h2222); drop_cs();
    idle(TWP + 40);
    rd(6'd21, 16'h1111, "R11 busy frame ignored");

    // R9: chip select raised only after the end
    hdr(2'b01, 6'd30); data(16'h7777); drop_cs();
    idle(TWP + 40);
    cs = 1'b1; idle(20);
    chk(dout == 1'b0, "R9 no late status", {15'b0, dout}, '0);
    drop_cs();
    rd(6'd30, 16'h7777, "R7 read pattern");

    idle(10);
    report();
  end
endmodule